// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmit Unit

This block is a byte-wide serial channel that moves one 8-bit word per transfer, a bit at a time, beside a shift clock. Software sees four byte registers on a simple write/read bus: a write-protect register, a control register, a rate register and a data register. A write to the data register while the channel is idle loads the word and starts a transfer. With the internal clock chosen, the unit makes its own shift clock: a prescaler (undivided, /8 or /32) feeds an 8-bit reload divider. Each clock half lasts (rate+1) prescaled ticks. With the external clock chosen, the unit follows an incoming clock after a two-flop synchroniser.

Output data changes while the shift clock is low, and input data is sampled as the clock rises. After eight bits the received word can be read back from the data register and an interrupt flag is raised. Control writes are accepted only straight after the protect enable has been set. Outside a transfer, the serial output rests at a programmable level.

The sequencer has four states. `ST_IDLE` waits for a data write. `ST_SHIFT_LO` and `ST_SHIFT_HI` are the two clock halves of an internally clocked bit. `ST_EXT_RUN` is an externally clocked transfer. The transitions are:
- start-internal: `ST_IDLE` to `ST_SHIFT_LO`.
- start-external: `ST_IDLE` to `ST_EXT_RUN`.
- rise: `ST_SHIFT_LO` to `ST_SHIFT_HI` when the divider expires.
- next-bit: `ST_SHIFT_HI` to `ST_SHIFT_LO` when the divider expires and bits remain.
- finish: `ST_SHIFT_HI` to `ST_IDLE` when the divider expires after the eighth bit.
- ext-finish: `ST_EXT_RUN` to `ST_IDLE` on the eighth synchronised rising edge.

Top module: `sio_xmit_unit`

## Requirements
- R1: After reset all four registers read 0, the serial clock output is 1, the serial output is 0, the output enable is 0 and the interrupt flag is 0.
- R2: Register addresses are: protect 0 (enable in bit 0), control 1, rate 2, data 3. A control write changes the control register only when the protect enable is 1. Any bus write to an address other than 0 clears the protect enable, so the control write must come next.
- R3: Control bits [1:0] pick the prescaler: 00 undivided, 01 /8, 10 /32. Control bit 6 = 1 selects the internal clock. The internal shift clock falls on the cycle the transfer starts. Each low half and high half then lasts (rate+1)×P system cycles, where P is 1, 8 or 32. Whenever no transfer runs, the shift clock is 1.
- R4: Control bit 4 picks the bit order: 0 sends the data register's bit 0 first, 1 sends bit 7 first. The serial output changes only while the shift clock is low, so it is stable during every high half.
- R5: The serial input is sampled on each rise of the shift clock. After eight bits, reading the data register returns the received word: with LSB-first order the first received bit is bit 0, with MSB-first order it is bit 7.
- R6: When idle with the internal clock selected, the serial output equals control bit 7.
- R7: The output enable is 1 exactly when control bit 3 (route to pin) is 1 and control bit 2 (output disable) is 0.
- R8: Writes to the rate or data register during a transfer are ignored. The rate reads back unchanged, and the transmitted bits and received word are unaffected.
- R9: The interrupt flag rises on the cycle the transfer ends. It is cleared when the next transfer starts.
- R10: With control bit 6 = 0, a transfer advances on the external clock input. Output bits change after its falling edges and input bits are sampled after its rising edges. The eighth rising edge ends the transfer and raises the flag, and the shift clock output stays 1 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr |
| ser_in | input | 1 | Serial data input |
| ext_clk_in | input | 1 | External shift clock |
| ser_out | output | 1 | Serial data output |
| ser_clk_out | output | 1 | Generated shift clock |
| ser_out_en | output | 1 | Drive enable for the serial output |
| irq_flag | output | 1 | Transfer-complete request |

## Verification
The hardest situation to reach is a rate or data write that lands in the middle of a shift. Such a write needs exact knowledge of which bit is on the wire. The bench therefore follows the shift clock at every cycle while a transfer runs. It injects those writes on the bus at a chosen bit index, then confirms through readback and the transmitted stream that they had no effect. Half-period lengths are measured live for every prescaler tap, with constrained-random rate values, bit orders and data words.

// File: rtl/sio_xmit_pkg.sv
package sio_xmit_pkg;

    typedef enum logic [1:0] {
        A_PROT = 2'd0,
        A_CTRL = 2'd1,
        A_RATE = 2'd2,
        A_DATA = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT_LO,
        ST_SHIFT_HI,
        ST_EXT_RUN
    } xfer_state_e;

    // control byte layout, msb first
    typedef struct packed {
        logic       idle_hi;
        logic       internal;
        logic       spare;
        logic       msb_first;
        logic       port_sel;
        logic       out_dis;
        logic [1:0] clk_sel;
    } ctrl_t;

endpackage

// File: rtl/sio_regfile.sv
module sio_regfile
    import sio_xmit_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] rx_data,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              prot_q,
    output ctrl_t             ctl_q,
    output logic [RATE_W-1:0] brg_q,
    output logic              load_req
);

    localparam int CTRL_W = $bits(ctrl_t);

    logic wr_prot, wr_ctrl, wr_rate, wr_data;

    always_comb begin
        wr_prot = bus_wr && (reg_addr_e'(bus_addr) == A_PROT);
        wr_ctrl = bus_wr && (reg_addr_e'(bus_addr) == A_CTRL);
        wr_rate = bus_wr && (reg_addr_e'(bus_addr) == A_RATE);
        wr_data = bus_wr && (reg_addr_e'(bus_addr) == A_DATA);
    end

    // protect enable lives exactly until the next write elsewhere
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
        end else if (wr_prot) begin
            prot_q <= bus_wdata[0];
        end else if (bus_wr) begin
            prot_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_ctrl && prot_q) begin
            ctl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brg_q <= '0;
        end else if (wr_rate && !busy) begin
            brg_q <= bus_wdata[RATE_W-1:0];
        end
    end

    assign load_req = wr_data && !busy;

    always_comb begin
        bus_rdata = '0;
        unique case (reg_addr_e'(bus_addr))
            A_PROT: bus_rdata = DATA_W'(prot_q);
            A_CTRL: bus_rdata = DATA_W'(ctl_q);
            A_RATE: bus_rdata = DATA_W'(brg_q);
            A_DATA: bus_rdata = rx_data;
        endcase
    end

endmodule

// File: rtl/sio_rate_gen.sv
module sio_rate_gen #(
    parameter int RATE_W   = 8,
    parameter int TAP_A_LG = 3,
    parameter int TAP_B_LG = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic [1:0]        clk_sel,
    input  logic [RATE_W-1:0] brg,
    output logic              half_done
);

    localparam int PRE_W = TAP_B_LG;

    logic [PRE_W-1:0]  pre_cnt;
    logic [RATE_W-1:0] div_cnt;
    logic              tick;

    always_comb begin
        unique case (clk_sel)
            2'b00:   tick = 1'b1;
            2'b01:   tick = &pre_cnt[TAP_A_LG-1:0];
            2'b10:   tick = &pre_cnt;
            default: tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (restart) begin
            pre_cnt <= '0;
            div_cnt <= brg;
        end else if (run) begin
            pre_cnt <= pre_cnt + 1'b1;
            if (tick) begin
                div_cnt <= (div_cnt == '0) ? brg : div_cnt - 1'b1;
            end
        end
    end

    assign half_done = run && tick && (div_cnt == '0);

endmodule

// File: rtl/sio_shift_fsm.sv
module sio_shift_fsm
    import sio_xmit_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic [DATA_W-1:0] load_data,
    input  logic              internal,
    input  logic              msb_first,
    input  logic              half_done,
    input  logic              ext_clk_in,
    input  logic              ser_in,
    output logic              busy,
    output logic              run,
    output logic              restart,
    output logic [DATA_W-1:0] sh_q,
    output logic              out_bit,
    output logic              sclk_q,
    output logic              irq_q
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    xfer_state_e      state, nxt;
    logic [CNT_W-1:0] bit_cnt;
    logic [SYNC_N:0]  ext_s;
    logic             ext_rise, ext_fall, last_bit;

    function automatic logic end_bit(input logic [DATA_W-1:0] v, input logic msb);
        return msb ? v[DATA_W-1] : v[0];
    endfunction

    function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] v,
                                                   input logic b, input logic msb);
        return msb ? {v[DATA_W-2:0], b} : {b, v[DATA_W-1:1]};
    endfunction

    // external clock synchroniser plus edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_s <= '1;
        else        ext_s <= {ext_s[SYNC_N-1:0], ext_clk_in};
    end

    assign ext_rise = ext_s[SYNC_N-1] && !ext_s[SYNC_N];
    assign ext_fall = !ext_s[SYNC_N-1] && ext_s[SYNC_N];
    assign last_bit = (bit_cnt == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (load_req) nxt = internal ? ST_SHIFT_LO : ST_EXT_RUN;
            ST_SHIFT_LO: if (half_done) nxt = ST_SHIFT_HI;
            ST_SHIFT_HI: if (half_done) nxt = last_bit ? ST_IDLE : ST_SHIFT_LO;
            ST_EXT_RUN:  if (ext_rise && last_bit) nxt = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            out_bit <= 1'b0;
            bit_cnt <= '0;
            sclk_q  <= 1'b1;
            irq_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (load_req) begin
                        sh_q    <= load_data;
                        out_bit <= end_bit(load_data, msb_first);
                        bit_cnt <= '0;
                        irq_q   <= 1'b0;
                        sclk_q  <= !internal;
                    end
                end
                ST_SHIFT_LO: begin
                    if (half_done) begin
                        sclk_q <= 1'b1;
                        sh_q   <= shift_in(sh_q, ser_in, msb_first);
                    end
                end
                ST_SHIFT_HI: begin
                    if (half_done) begin
                        if (last_bit) begin
                            irq_q <= 1'b1;
                        end else begin
                            sclk_q  <= 1'b0;
                            bit_cnt <= bit_cnt + 1'b1;
                            out_bit <= end_bit(sh_q, msb_first);
                        end
                    end
                end
                ST_EXT_RUN: begin
                    if (ext_rise) begin
                        sh_q <= shift_in(sh_q, ser_in, msb_first);
                        if (last_bit) irq_q <= 1'b1;
                        else          bit_cnt <= bit_cnt + 1'b1;
                    end else if (ext_fall) begin
                        out_bit <= end_bit(sh_q, msb_first);
                    end
                end
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign run     = (state == ST_SHIFT_LO) || (state == ST_SHIFT_HI);
    assign restart = (state == ST_IDLE) && load_req && internal;

endmodule

// File: rtl/sio_xmit_unit.sv
module sio_xmit_unit
    import sio_xmit_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ser_in,
    input  logic              ext_clk_in,
    output logic              ser_out,
    output logic              ser_clk_out,
    output logic              ser_out_en,
    output logic              irq_flag
);

    logic              prot_q;
    ctrl_t             ctl_q;
    logic [RATE_W-1:0] brg_q;
    logic              load_req, busy, run_int, restart, half_done;
    logic [DATA_W-1:0] sh_q;
    logic              out_bit, sclk_q, irq_q;

    sio_regfile #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .busy(busy), .rx_data(sh_q), .bus_rdata(bus_rdata),
        .prot_q(prot_q), .ctl_q(ctl_q), .brg_q(brg_q), .load_req(load_req)
    );

    sio_rate_gen #(.RATE_W(RATE_W)) u_rate (
        .clk(clk), .rst_n(rst_n),
        .restart(restart), .run(run_int),
        .clk_sel(ctl_q.clk_sel), .brg(brg_q), .half_done(half_done)
    );

    sio_shift_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .load_req(load_req), .load_data(bus_wdata),
        .internal(ctl_q.internal), .msb_first(ctl_q.msb_first),
        .half_done(half_done), .ext_clk_in(ext_clk_in), .ser_in(ser_in),
        .busy(busy), .run(run_int), .restart(restart),
        .sh_q(sh_q), .out_bit(out_bit), .sclk_q(sclk_q), .irq_q(irq_q)
    );

    always_comb begin
        if (!busy && ctl_q.internal) ser_out = ctl_q.idle_hi;
        else                         ser_out = out_bit;
    end

    assign ser_out_en  = ctl_q.port_sel && !ctl_q.out_dis;
    assign ser_clk_out = sclk_q;
    assign irq_flag    = irq_q;

endmodule

// File: rtl/sio_xmit_chk.sv
module sio_xmit_chk #(
    parameter int RATE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic              prot_q,
    input logic [7:0]        ctl_q,
    input logic [RATE_W-1:0] brg_q,
    input logic              busy,
    input logic              run_int,
    input logic              ser_out,
    input logic              ser_clk_out,
    input logic              irq_flag
);

    p_ctl_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && !prot_q) |=> $stable(ctl_q));

    p_prot_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != 2'd0) |=> !prot_q);

    p_clk_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ser_clk_out);

    p_out_steady_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_int && ser_clk_out && $past(ser_clk_out) && $past(run_int)) |-> $stable(ser_out));

    p_rate_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == 2'd2) |=> $stable(brg_q));

    p_irq_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $fell(busy));

    p_irq_clear_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !irq_flag);

endmodule

bind sio_xmit_unit sio_xmit_chk #(.RATE_W(RATE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .prot_q(prot_q), .ctl_q(ctl_q), .brg_q(brg_q), .busy(busy),
    .run_int(run_int), .ser_out(ser_out), .ser_clk_out(ser_clk_out),
    .irq_flag(irq_flag)
);

// File: tb/sio_xmit_unit_tb.sv
module sio_xmit_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ser_in = 1'b0;
    logic       ext_clk_in = 1'b1;
    logic       ser_out, ser_clk_out, ser_out_en, irq_flag;

    int total = 0;
    int bad   = 0;
    bit timed_out = 1'b0;

    always #10 clk = ~clk;

    sio_xmit_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_in(ser_in),
        .ext_clk_in(ext_clk_in), .ser_out(ser_out), .ser_clk_out(ser_clk_out),
        .ser_out_en(ser_out_en), .irq_flag(irq_flag)
    );

    initial begin
        repeat (180000) @(posedge clk);
        timed_out = 1'b1;
        bad++;
        $display("FAIL watchdog: act=expired exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // k-th bit on the wire sits at bit k of the result
    function automatic logic [7:0] wire_order(input logic [7:0] v, input logic msb);
        return msb ? rev8(v) : v;
    endfunction

    function automatic int prescale(input logic [1:0] sel);
        return (sel == 2'b00) ? 1 : (sel == 2'b01) ? 8 : 32;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_ctl(input logic [7:0] c);
        bus_write(2'd0, 8'h01);
        bus_write(2'd1, c);
    endtask

    task automatic run_internal(input logic [7:0] c, input logic [7:0] brg,
                                input logic [7:0] data, input logic [7:0] rx,
                                input bit poke);
        int         h, cnt, k, phase_err, pk;
        logic       prev;
        logic [7:0] got, rd;
        set_ctl(c);
        bus_write(2'd2, brg);
        h = (int'(brg) + 1) * prescale(c[1:0]);
        ser_in = rx[0];
        bus_write(2'd3, data);
        chk("R9 flag cleared on start", 32'(irq_flag), 32'd0);
        chk("R3 clock falls at start", 32'(ser_clk_out), 32'd0);
        prev = 1'b0; cnt = 1; k = 0; phase_err = 0; pk = 0; got = '0;
        while (!irq_flag && !timed_out) begin
            @(negedge clk);
            if (poke && k == 3 && pk == 0) begin
                bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = ~brg; pk = 1;
            end else if (poke && k == 5 && pk == 1) begin
                bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = ~data; pk = 2;
            end else begin
                bus_wr = 1'b0;
            end
            if (ser_clk_out !== prev) begin
                if (cnt != h) phase_err++;
                cnt = 1;
                prev = ser_clk_out;
                if (ser_clk_out) begin
                    if (k < 8) got[k] = ser_out;
                    k++;
                end else if (k < 8) begin
                    ser_in = rx[k];
                end
            end else begin
                cnt++;
            end
        end
        bus_wr = 1'b0;
        chk("R3 half period length", 32'(phase_err), 32'd0);
        chk("R3 bit count", 32'(k), 32'd8);
        chk("R4 transmitted stream", 32'(got), 32'(wire_order(data, c[4])));
        bus_read(2'd3, rd);
        chk("R5 received word", 32'(rd), 32'(wire_order(rx, c[4])));
        chk("R9 flag raised at end", 32'(irq_flag), 32'd1);
        chk("R6 idle level after transfer", 32'(ser_out), 32'(c[7]));
        if (poke) begin
            bus_read(2'd2, rd);
            chk("R8 rate unchanged by busy write", 32'(rd), 32'(brg));
        end
    endtask

    task automatic run_external(input logic [7:0] c, input logic [7:0] data,
                                input logic [7:0] rx);
        logic [7:0] got, rd;
        int         clk_low;
        set_ctl(c);
        bus_write(2'd3, data);
        clk_low = 0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            ext_clk_in = 1'b0;
            ser_in = rx[k];
            repeat (6) @(negedge clk);
            got[k] = ser_out;
            if (!ser_clk_out) clk_low++;
            ext_clk_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        chk("R10 external stream", 32'(got), 32'(wire_order(data, c[4])));
        bus_read(2'd3, rd);
        chk("R10 external received word", 32'(rd), 32'(wire_order(rx, c[4])));
        chk("R10 external flag", 32'(irq_flag), 32'd1);
        chk("R10 clock output held high", 32'(clk_low), 32'd0);
    endtask

    initial begin
        logic [7:0] rd;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            bus_read(2'(a), rd);
            chk("R1 register reset", 32'(rd), 32'd0);
        end
        chk("R1 clock idle", 32'(ser_clk_out), 32'd1);
        chk("R1 output low", 32'(ser_out), 32'd0);
        chk("R1 enable off", 32'(ser_out_en), 32'd0);
        chk("R1 flag clear", 32'(irq_flag), 32'd0);

        // R2 protect gating
        bus_write(2'd1, 8'hC8);
        bus_read(2'd1, rd);
        chk("R2 unprotected write ignored", 32'(rd), 32'd0);
        bus_write(2'd0, 8'h01);
        bus_read(2'd0, rd);
        chk("R2 protect set", 32'(rd), 32'd1);
        bus_write(2'd2, 8'h00);
        bus_read(2'd0, rd);
        chk("R2 protect dropped by other write", 32'(rd), 32'd0);
        bus_write(2'd1, 8'hC8);
        bus_read(2'd1, rd);
        chk("R2 late control write ignored", 32'(rd), 32'd0);
        set_ctl(8'h08);
        bus_read(2'd1, rd);
        chk("R2 protected write accepted", 32'(rd), 32'h08);
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, rd);
        chk("R2 second write ignored", 32'(rd), 32'h08);

        // R7 output enable
        chk("R7 routed and driven", 32'(ser_out_en), 32'd1);
        set_ctl(8'h0C);
        chk("R7 disabled", 32'(ser_out_en), 32'd0);
        set_ctl(8'h00);
        chk("R7 not routed", 32'(ser_out_en), 32'd0);

        // R6 idle level
        set_ctl(8'hC0);
        chk("R6 idle high", 32'(ser_out), 32'd1);
        set_ctl(8'h40);
        chk("R6 idle low", 32'(ser_out), 32'd0);

        // directed internal transfers (bit6 internal, bit3 routed)
        run_internal(8'h48, 8'd0, 8'hA5, 8'h3C, 1'b0);
        run_internal(8'hD8, 8'd2, 8'h81, 8'hC4, 1'b1);
        run_internal(8'h49, 8'd1, 8'h5B, 8'h96, 1'b0);
        run_internal(8'hCA, 8'd0, 8'h17, 8'hE8, 1'b1);
        run_internal(8'h58, 8'd0, 8'h00, 8'hFF, 1'b1);

        // constrained random internal transfers
        for (int t = 0; t < 10; t++) begin
            logic [1:0] sel;
            logic [7:0] c, brg;
            sel = ($urandom % 4 == 0) ? 2'b01 : 2'b00;
            brg = 8'($urandom % 4);
            c = {1'($urandom), 1'b1, 1'b0, 1'($urandom), 1'b1, 1'b0, sel};
            run_internal(c, brg, 8'($urandom), 8'($urandom), 1'($urandom));
        end

        // external clock transfers (bit6 = 0)
        run_external(8'h08, 8'hC3, 8'h5A);
        run_external(8'h18, 8'h4E, 8'h71);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule